// File: doc/BRIEF.md
# Flash Query Geometry Discovery Engine

This engine runs on the host side of a 16-bit parallel NOR flash bus. It learns the erase layout of the flash without help from software. After a start pulse it puts the flash into query mode and checks the three-letter query signature. It then reads the device size exponent and the number of erase regions. For each region it reads the sector count and the sector size. Next it follows the pointer to the primary vendor table, checks that table's signature, and reads whether the device allows reads and writes while an erase is suspended. Before it reports completion it always puts the flash back in read-array mode, whether the run succeeded or failed.

The region descriptors go into a small register file. A combinational lookup port turns a (region, sector index) pair into a byte base address. Regions are placed back to back from address 0, so the base is the total size of all lower regions plus the index times the sector size of the selected region. This covers top-boot and bottom-boot parts with up to four regions of different sizes.

The flash master port is synchronous. A strobe with a write flag, a byte address and write data is held for one cycle. Read data is returned on the cycle after a read strobe. Only the low byte of each query word is used.

Top module: `geo_probe`

## Requirements
- R1: After `start`, the first flash access is a write of 0x0098 to byte address 0x0000AA (word 0x55). No read happens outside query mode. Every access uses an even byte address equal to twice the word address.
- R2: The low bytes of words 0x10, 0x11 and 0x12 must be 0x51, 0x52 and 0x59. Any mismatch ends the run with `err` high.
- R3: `dev_log2` takes the low byte of word 0x27, which is the base-2 logarithm of the device size in bytes.
- R4: The low byte of word 0x2C is the region count. A value of 0 or a value above 4 ends the run with `err` high. Otherwise the value appears on `region_cnt`.
- R5: Region r is described by words 0x2D+4r to 0x30+4r. Its first two bytes, low byte first, hold the sector count minus one. Its last two bytes, low byte first, hold the sector size in units of 256 bytes. `lk_sectors` and `lk_sect_bytes` report the count and the byte size of the region chosen by `lk_region`.
- R6: The primary table pointer is formed from word 0x15 (low byte) and word 0x16 (high byte). A pointer below 0x2D + 4 × region count ends the run with `err` high.
- R7: The words at pointer+0, +1 and +2 must read 0x50, 0x52 and 0x49, or the run ends with `err` high. `suspend_rw` is 1 exactly when the byte at pointer+6 equals 0x02.
- R8: Every run, whether it succeeds or fails, writes 0x00F0 to byte address 0 in the cycle just before `done`. This returns the flash to read-array mode.
- R9: `done` is a one-cycle pulse, given once per run. `busy` is high from the cycle after `start` up to and including the `done` cycle. A `start` that arrives while `busy` is high is ignored.
- R10: `lk_base` equals the sum of the sizes of all regions below `lk_region`, plus `lk_index` times the sector size of `lk_region`. Every `start` clears the table, and a region at or above the count reports zero sectors and zero size.
- R11: After reset, `busy`, `done`, `err`, `fl_cs`, `region_cnt` and `lk_sectors` are all 0.
- R12: The upper byte of every word read from the flash has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a discovery run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run failed a check; held until the next start |
| fl_cs | output | 1 | Flash access strobe |
| fl_we | output | 1 | Access is a write |
| fl_addr | output | 24 | Flash byte address |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data, valid the cycle after a read strobe |
| dev_log2 | output | 8 | Device size exponent |
| region_cnt | output | 3 | Number of erase regions |
| suspend_rw | output | 1 | Read/write allowed during erase suspend |
| lk_region | input | 2 | Lookup region select |
| lk_index | input | 16 | Lookup sector index within the region |
| lk_base | output | 32 | Byte base address of the selected sector |
| lk_sectors | output | 17 | Sector count of the selected region |
| lk_sect_bytes | output | 32 | Sector size in bytes of the selected region |

## Verification
A bench flash model answers query reads from an image built out of a layout description. It puts random garbage in the upper byte of every word. Its first job is to tell a correct region walk apart from an off-by-one in region order or byte order. For this the mirrored top-boot and bottom-boot layouts use the same four sector sizes in opposite order, and a single-region uniform part is run as well. Random layouts with odd sector counts and sizes that are not powers of two check the prefix-sum lookup and the 16-bit field assembly. Directed images then break one check at a time: the signature, a region count of zero, a region count of five, a pointer that is too low, the vendor-table letters, and a suspend code other than 2. Each one must end in exactly one done pulse, with the flash back in read-array mode.

// File: rtl/geo_pkg.sv
// Shared constants and types for the flash geometry discovery engine.
// Assumes a single x16 device: command and query addresses are word
// addresses, and only the low byte of a query word carries data.
package geo_pkg;
    localparam logic [7:0]  CMD_QUERY = 8'h98;
    localparam logic [7:0]  CMD_EXIT  = 8'hF0;
    localparam logic [15:0] W_ENTER   = 16'h0055;
    localparam logic [15:0] W_SIG     = 16'h0010;
    localparam logic [15:0] W_PRI     = 16'h0015;
    localparam logic [15:0] W_SIZE    = 16'h0027;
    localparam logic [15:0] W_NREG    = 16'h002C;
    localparam logic [15:0] W_DESC    = 16'h002D;
    localparam logic [15:0] PRI_SUSP_OFS = 16'd6;
    localparam logic [7:0]  CH_Q = 8'h51;
    localparam logic [7:0]  CH_R = 8'h52;
    localparam logic [7:0]  CH_Y = 8'h59;
    localparam logic [7:0]  CH_P = 8'h50;
    localparam logic [7:0]  CH_I = 8'h49;
    localparam logic [7:0]  SUSP_RW_CODE = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ENTER, ST_RD, ST_CAP, ST_EXIT, ST_FIN
    } ctl_state_t;

    typedef enum logic [3:0] {
        STP_SIG0, STP_SIG1, STP_SIG2, STP_SIZE, STP_NREG,
        STP_PLO, STP_PHI, STP_DESC, STP_PSIG0, STP_PSIG1,
        STP_PSIG2, STP_SUSP
    } step_t;
endpackage

// File: rtl/geo_seq.sv
// Discovery sequencer: issues query-mode entry, walks the query structure
// one word at a time (strobe cycle, then capture cycle), checks signatures
// and limits, streams descriptor bytes to the region table, and always
// leaves query mode before pulsing done.
// Assumes read data is valid exactly one cycle after a read strobe.
module geo_seq
    import geo_pkg::*;
#(
    parameter int NREG    = 4,
    parameter int FADDR_W = 24,
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CNT_W  = $clog2(NREG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               fl_cs,
    output logic               fl_we,
    output logic [FADDR_W-1:0] fl_addr,
    output logic [15:0]        fl_wdata,
    input  logic [15:0]        fl_rdata,
    output logic [7:0]         dev_log2,
    output logic [CNT_W-1:0]   region_cnt,
    output logic               suspend_rw,
    output logic               tbl_clr,
    output logic               tbl_we,
    output logic [RIDX_W-1:0]  tbl_ridx,
    output logic [1:0]         tbl_bsel,
    output logic [7:0]         tbl_data
);
    ctl_state_t         st;
    step_t              stp;
    logic [RIDX_W-1:0]  ridx;
    logic [1:0]         bsel;
    logic [15:0]        pri;
    logic               bad;
    logic               err_q;
    logic [7:0]         rbyte;
    logic [15:0]        rd_word;
    logic               unused_hi;

    assign rbyte     = fl_rdata[7:0];
    assign unused_hi = ^fl_rdata[15:8];

    // Word address of the query read selected by the current step.
    always_comb begin
        case (stp)
            STP_SIG0:  rd_word = W_SIG;
            STP_SIG1:  rd_word = W_SIG + 16'd1;
            STP_SIG2:  rd_word = W_SIG + 16'd2;
            STP_SIZE:  rd_word = W_SIZE;
            STP_NREG:  rd_word = W_NREG;
            STP_PLO:   rd_word = W_PRI;
            STP_PHI:   rd_word = W_PRI + 16'd1;
            STP_DESC:  rd_word = W_DESC + 16'(ridx) * 16'd4 + 16'(bsel);
            STP_PSIG0: rd_word = pri;
            STP_PSIG1: rd_word = pri + 16'd1;
            STP_PSIG2: rd_word = pri + 16'd2;
            STP_SUSP:  rd_word = pri + PRI_SUSP_OFS;
            default:   rd_word = '0;
        endcase
    end

    // Flash master port, decoded from the control state.
    always_comb begin
        fl_cs    = (st == ST_ENTER) || (st == ST_RD) || (st == ST_EXIT);
        fl_we    = (st == ST_ENTER) || (st == ST_EXIT);
        fl_addr  = '0;
        fl_wdata = '0;
        if (st == ST_ENTER) begin
            fl_addr  = FADDR_W'({W_ENTER, 1'b0});
            fl_wdata = {8'h00, CMD_QUERY};
        end else if (st == ST_RD) begin
            fl_addr  = FADDR_W'({rd_word, 1'b0});
        end else if (st == ST_EXIT) begin
            fl_wdata = {8'h00, CMD_EXIT};
        end
    end

    // Handshake and table write port.
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_FIN);
    assign err      = err_q;
    assign tbl_clr  = (st == ST_IDLE) && start;
    assign tbl_we   = (st == ST_CAP) && (stp == STP_DESC);
    assign tbl_ridx = ridx;
    assign tbl_bsel = bsel;
    assign tbl_data = rbyte;

    // Main control: advances state and step, captures results, flags failures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            stp        <= STP_SIG0;
            ridx       <= '0;
            bsel       <= '0;
            pri        <= '0;
            bad        <= 1'b0;
            err_q      <= 1'b0;
            dev_log2   <= '0;
            region_cnt <= '0;
            suspend_rw <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st         <= ST_ENTER;
                    stp        <= STP_SIG0;
                    ridx       <= '0;
                    bsel       <= '0;
                    pri        <= '0;
                    bad        <= 1'b0;
                    err_q      <= 1'b0;
                    dev_log2   <= '0;
                    region_cnt <= '0;
                    suspend_rw <= 1'b0;
                end
                ST_ENTER: st <= ST_RD;
                ST_RD:    st <= ST_CAP;
                ST_CAP: begin
                    st <= ST_RD;
                    case (stp)
                        STP_SIG0: if (rbyte != CH_Q) begin bad <= 1'b1; st <= ST_EXIT; end
                                  else stp <= STP_SIG1;
                        STP_SIG1: if (rbyte != CH_R) begin bad <= 1'b1; st <= ST_EXIT; end
                                  else stp <= STP_SIG2;
                        STP_SIG2: if (rbyte != CH_Y) begin bad <= 1'b1; st <= ST_EXIT; end
                                  else stp <= STP_SIZE;
                        STP_SIZE: begin
                            dev_log2 <= rbyte;
                            stp      <= STP_NREG;
                        end
                        STP_NREG: if (rbyte == 8'd0 || rbyte > 8'(NREG)) begin
                            bad <= 1'b1;
                            st  <= ST_EXIT;
                        end else begin
                            region_cnt <= CNT_W'(rbyte);
                            stp        <= STP_PLO;
                        end
                        STP_PLO: begin
                            pri[7:0] <= rbyte;
                            stp      <= STP_PHI;
                        end
                        STP_PHI: if ({rbyte, pri[7:0]} < W_DESC + 16'(region_cnt) * 16'd4) begin
                            bad <= 1'b1;
                            st  <= ST_EXIT;
                        end else begin
                            pri[15:8] <= rbyte;
                            stp       <= STP_DESC;
                        end
                        STP_DESC: begin
                            bsel <= bsel + 2'd1;
                            if (bsel == 2'd3) begin
                                if (ridx == RIDX_W'(region_cnt - CNT_W'(1))) stp <= STP_PSIG0;
                                else ridx <= ridx + RIDX_W'(1);
                            end
                        end
                        STP_PSIG0: if (rbyte != CH_P) begin bad <= 1'b1; st <= ST_EXIT; end
                                   else stp <= STP_PSIG1;
                        STP_PSIG1: if (rbyte != CH_R) begin bad <= 1'b1; st <= ST_EXIT; end
                                   else stp <= STP_PSIG2;
                        STP_PSIG2: if (rbyte != CH_I) begin bad <= 1'b1; st <= ST_EXIT; end
                                   else stp <= STP_SUSP;
                        STP_SUSP: begin
                            suspend_rw <= (rbyte == SUSP_RW_CODE);
                            st         <= ST_EXIT;
                        end
                        default: st <= ST_EXIT;
                    endcase
                end
                ST_EXIT: begin
                    err_q <= bad;
                    st    <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_ENTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (fl_cs && fl_we && fl_addr == FADDR_W'(24'hAA) && fl_wdata == 16'h0098)); // R1
    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (region_cnt >= CNT_W'(1) && region_cnt <= CNT_W'(NREG))); // R4
    AST_EXIT_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fl_cs && fl_we && fl_addr == '0 && fl_wdata == 16'h00F0)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_cs); // R9
endmodule

// File: rtl/geo_table.sv
// Region descriptor register file with a combinational sector-base lookup.
// Each region keeps sector count minus one and size in 256-byte units plus
// a valid bit; regions are placed back to back from byte address 0.
// Assumes the sequencer writes descriptor bytes in order 0..3 per region.
module geo_table #(
    parameter int NREG    = 4,
    parameter int ADDR_W  = 32,
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_clr,
    input  logic              tbl_we,
    input  logic [RIDX_W-1:0] tbl_ridx,
    input  logic [1:0]        tbl_bsel,
    input  logic [7:0]        tbl_data,
    input  logic [RIDX_W-1:0] lk_region,
    input  logic [15:0]       lk_index,
    output logic [ADDR_W-1:0] lk_base,
    output logic [16:0]       lk_sectors,
    output logic [ADDR_W-1:0] lk_sect_bytes
);
    logic [15:0]       cnt_m1 [NREG];
    logic [15:0]       units  [NREG];
    logic [NREG-1:0]   vld;
    logic [ADDR_W-1:0] span   [NREG];
    logic [ADDR_W-1:0] pre    [NREG+1];

    // Descriptor storage: cleared at each start, filled byte by byte.
    always_ff @(posedge clk) begin
        if (!rst_n || tbl_clr) begin
            for (int k = 0; k < NREG; k++) begin
                cnt_m1[k] <= '0;
                units[k]  <= '0;
            end
            vld <= '0;
        end else if (tbl_we) begin
            case (tbl_bsel)
                2'd0:    cnt_m1[tbl_ridx][7:0]  <= tbl_data;
                2'd1:    cnt_m1[tbl_ridx][15:8] <= tbl_data;
                2'd2:    units[tbl_ridx][7:0]   <= tbl_data;
                default: units[tbl_ridx][15:8]  <= tbl_data;
            endcase
            vld[tbl_ridx] <= 1'b1;
        end
    end

    // Byte span of each region.
    for (genvar g = 0; g < NREG; g++) begin : g_span
        assign span[g] = vld[g]
            ? (((ADDR_W'(cnt_m1[g]) + ADDR_W'(1)) * ADDR_W'(units[g])) << 8)
            : '0;
    end

    // Running start address of each region.
    always_comb begin
        pre[0] = '0;
        for (int k = 0; k < NREG; k++) pre[k+1] = pre[k] + span[k];
    end

    assign lk_sect_bytes = ADDR_W'(units[lk_region]) << 8;
    assign lk_base       = pre[lk_region] + ((ADDR_W'(lk_index) * ADDR_W'(units[lk_region])) << 8);
    assign lk_sectors    = vld[lk_region] ? ({1'b0, cnt_m1[lk_region]} + 17'd1) : '0;

    AST_NO_WRITE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clr |-> !tbl_we); // R10
endmodule

// File: rtl/geo_probe.sv
// Top of the flash geometry discovery engine: sequencer plus region table.
// Assumes one x16 flash on a synchronous master port with one-cycle read
// latency; results stay valid until the next start.
module geo_probe #(
    parameter int NREG    = 4,
    parameter int FADDR_W = 24,
    parameter int ADDR_W  = 32,
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CNT_W  = $clog2(NREG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               fl_cs,
    output logic               fl_we,
    output logic [FADDR_W-1:0] fl_addr,
    output logic [15:0]        fl_wdata,
    input  logic [15:0]        fl_rdata,
    output logic [7:0]         dev_log2,
    output logic [CNT_W-1:0]   region_cnt,
    output logic               suspend_rw,
    input  logic [RIDX_W-1:0]  lk_region,
    input  logic [15:0]        lk_index,
    output logic [ADDR_W-1:0]  lk_base,
    output logic [16:0]        lk_sectors,
    output logic [ADDR_W-1:0]  lk_sect_bytes
);
    logic              tbl_clr;
    logic              tbl_we;
    logic [RIDX_W-1:0] tbl_ridx;
    logic [1:0]        tbl_bsel;
    logic [7:0]        tbl_data;

    geo_seq #(.NREG(NREG), .FADDR_W(FADDR_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .err(err),
        .fl_cs(fl_cs), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .dev_log2(dev_log2), .region_cnt(region_cnt), .suspend_rw(suspend_rw),
        .tbl_clr(tbl_clr), .tbl_we(tbl_we), .tbl_ridx(tbl_ridx),
        .tbl_bsel(tbl_bsel), .tbl_data(tbl_data)
    );

    geo_table #(.NREG(NREG), .ADDR_W(ADDR_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .tbl_clr(tbl_clr), .tbl_we(tbl_we), .tbl_ridx(tbl_ridx),
        .tbl_bsel(tbl_bsel), .tbl_data(tbl_data),
        .lk_region(lk_region), .lk_index(lk_index),
        .lk_base(lk_base), .lk_sectors(lk_sectors), .lk_sect_bytes(lk_sect_bytes)
    );
endmodule

// File: tb/test_geo_probe.sv
`timescale 1ns/1ps
module test_geo_probe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, err, fl_cs, fl_we, suspend_rw;
    logic [23:0] fl_addr;
    logic [15:0] fl_wdata;
    logic [15:0] fl_rdata = 16'hFFFF;
    logic [7:0]  dev_log2;
    logic [2:0]  region_cnt;
    logic [1:0]  lk_region = 2'd0;
    logic [15:0] lk_index = 16'd0;
    logic [31:0] lk_base, lk_sect_bytes;
    logic [16:0] lk_sectors;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    geo_probe i_geo_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
        .fl_cs(fl_cs), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .dev_log2(dev_log2), .region_cnt(region_cnt),
        .suspend_rw(suspend_rw), .lk_region(lk_region), .lk_index(lk_index),
        .lk_base(lk_base), .lk_sectors(lk_sectors), .lk_sect_bytes(lk_sect_bytes)
    );

    // Flash model: query image, mode tracking, junk in the upper byte.
    logic [7:0]  qimg [0:255];
    logic        qmode = 1'b0;
    int          rd_outside = 0;
    int          odd_addr = 0;
    logic [7:0]  last_wd = 8'h00;
    logic [23:0] last_wa = 24'h0;

    always @(posedge clk) begin
        if (fl_cs) begin
            if (fl_addr[0]) odd_addr <= odd_addr + 1;
            if (fl_we) begin
                last_wd <= fl_wdata[7:0];
                last_wa <= fl_addr;
                if (fl_wdata == 16'h0098 && fl_addr == 24'hAA) qmode <= 1'b1;
                else if (fl_wdata[7:0] == 8'hF0) qmode <= 1'b0;
            end else if (!qmode) begin
                rd_outside <= rd_outside + 1;
                fl_rdata   <= 16'hFFFF;
            end else if (fl_addr[23:9] != 0) begin
                fl_rdata <= {8'($urandom), 8'h00};
            end else begin
                fl_rdata <= {8'($urandom | 1), qimg[fl_addr[8:1]]};
            end
        end
    end

    // Layout under test.
    int ncfg, nregv, nlog, priv, suspv;
    int cm1 [4];
    int un  [4];

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_image();
        for (int i = 0; i < 256; i++) qimg[i] = 8'h00;
        qimg[16] = 8'h51; qimg[17] = 8'h52; qimg[18] = 8'h59;
        qimg[8'h27] = 8'(nlog);
        qimg[8'h2C] = 8'(nregv);
        qimg[8'h15] = 8'(priv);
        qimg[8'h16] = 8'(priv >> 8);
        for (int r = 0; r < 4; r++) begin
            if (r < ncfg) begin
                qimg[45 + 4*r]     = 8'(cm1[r]);
                qimg[45 + 4*r + 1] = 8'(cm1[r] >> 8);
                qimg[45 + 4*r + 2] = 8'(un[r]);
                qimg[45 + 4*r + 3] = 8'(un[r] >> 8);
            end
        end
        qimg[priv]     = 8'h50;
        qimg[priv + 1] = 8'h52;
        qimg[priv + 2] = 8'h49;
        qimg[priv + 3] = 8'h01;
        qimg[priv + 6] = 8'(suspv);
    endtask

    function automatic longint unsigned exp_base(int rg, int idx);
        longint unsigned s = 0;
        for (int k = 0; k < rg; k++)
            if (k < ncfg) s += longint'(cm1[k] + 1) * longint'(un[k]) * 256;
        if (rg < ncfg) s += longint'(idx) * longint'(un[rg]) * 256;
        return s & 64'hFFFF_FFFF;
    endfunction

    task automatic run_probe(input bit twice, output int dones, output bit errv);
        dones = 0;
        errv  = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (twice) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (done) begin dones++; errv = err; end
            if (dones > 0 && !busy) break;
        end
    endtask

    task automatic look(input int rg, input int idx);
        lk_region = 2'(rg);
        lk_index  = 16'(idx);
        #1;
        check("R10", "lk_base", lk_base, exp_base(rg, idx));
        check("R5", "lk_sectors", lk_sectors, (rg < ncfg) ? cm1[rg] + 1 : 0);
        check("R5", "lk_sect_bytes", lk_sect_bytes, (rg < ncfg) ? un[rg] * 256 : 0);
    endtask

    task automatic good_run(input string tag, input bit twice);
        int  d;
        bit  e;
        build_image();
        run_probe(twice, d, e);
        check("R9", {tag, " done count"}, d, 1);
        check("R2", {tag, " err"}, e, 0);
        check("R3", {tag, " dev_log2"}, dev_log2, nlog & 255);
        check("R4", {tag, " region_cnt"}, region_cnt, nregv);
        check("R7", {tag, " suspend_rw"}, suspend_rw, suspv == 2);
        check("R8", {tag, " read mode"}, qmode, 0);
        check("R8", {tag, " last write"}, {last_wa, last_wd}, 32'h0000_00F0);
        for (int r = 0; r < 4; r++) begin
            look(r, 0);
            if (r < ncfg) look(r, cm1[r]);
        end
    endtask

    task automatic bad_run(input string req, input string tag);
        int d;
        bit e;
        run_probe(1'b0, d, e);
        check(req, {tag, " err"}, e, 1);
        check("R9", {tag, " done count"}, d, 1);
        check("R8", {tag, " read mode"}, qmode, 0);
    endtask

    task automatic set4(input int a0, b0, a1, b1, a2, b2, a3, b3);
        cm1[0] = a0; un[0] = b0; cm1[1] = a1; un[1] = b1;
        cm1[2] = a2; un[2] = b2; cm1[3] = a3; un[3] = b3;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog: got hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "busy", busy, 0);
        check("R11", "done", done, 0);
        check("R11", "err", err, 0);
        check("R11", "fl_cs", fl_cs, 0);
        check("R11", "region_cnt", region_cnt, 0);
        check("R11", "lk_sectors", lk_sectors, 0);

        // Top-boot layout
        ncfg = 4; nregv = 4; nlog = 23; priv = 16'h40; suspv = 2;
        set4(126, 256, 0, 128, 1, 32, 0, 64);
        good_run("top-boot", 1'b0);
        check("R12", "top-boot region_cnt with junk upper bytes", region_cnt, 4);

        // Bottom-boot layout (mirrored)
        set4(0, 64, 1, 32, 0, 128, 126, 256);
        good_run("bottom-boot", 1'b0);

        // Uniform single region; unused regions report zero
        ncfg = 1; nregv = 1; priv = 16'h31;
        set4(127, 256, 0, 0, 0, 0, 0, 0);
        good_run("uniform", 1'b0);

        // Start while busy is ignored
        ncfg = 2; nregv = 2; priv = 16'h35; suspv = 2;
        set4(3, 16, 9, 1, 0, 0, 0, 0);
        good_run("restart-while-busy R9", 1'b1);

        // Suspend code other than 2
        suspv = 1;
        good_run("suspend-1 R7", 1'b0);
        suspv = 2;

        // Broken query signature
        ncfg = 4; nregv = 4; priv = 16'h40;
        set4(126, 256, 0, 128, 1, 32, 0, 64);
        build_image(); qimg[18] = 8'h58;
        bad_run("R2", "bad Y");
        check("R2", "lookup empty after failed sig", lk_sectors, 0);

        // Region count out of range
        build_image(); qimg[8'h2C] = 8'd0;
        bad_run("R4", "zero regions");
        build_image(); qimg[8'h2C] = 8'd5;
        bad_run("R4", "five regions");

        // Pointer one below the limit, then exactly at the limit
        priv = 16'h3C; build_image();
        bad_run("R6", "pointer too low");
        priv = 16'h3D; good_run("pointer at limit R6", 1'b0);

        // Broken vendor table letters
        priv = 16'h40; build_image(); qimg[priv + 2] = 8'h48;
        bad_run("R7", "bad I");
        build_image(); qimg[priv] = 8'h51;
        bad_run("R7", "bad P");

        // Random layouts
        for (int it = 0; it < 25; it++) begin
            ncfg = 1 + int'($urandom % 4);
            nregv = ncfg;
            for (int r = 0; r < 4; r++) begin
                cm1[r] = int'($urandom % 300);
                un[r]  = 1 + int'($urandom % 600);
            end
            nlog  = int'($urandom % 32);
            priv  = 16'h2D + 4 * ncfg + int'($urandom % 8);
            suspv = int'($urandom % 3);
            good_run("random", 1'b0);
            for (int q = 0; q < 3; q++) begin
                int rg;
                rg = int'($urandom % ncfg);
                look(rg, int'($urandom % (cm1[rg] + 1)));
            end
        end

        check("R1", "reads outside query mode", rd_outside, 0);
        check("R1", "odd byte addresses", odd_addr, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule